// File: doc/BRIEF.md
# Super I/O Configuration Access Port

This block is the configuration-space front end of a multi-function I/O controller. It decodes two byte-wide locations on a simple 8-bit I/O bus. The index port sits at the base address and the data port at base+1. Software selects a register by writing its number to the index port. It then writes or reads that register through the data port.

The block comes out of reset locked. It opens only after the key byte 0x87 is written to the index port on two index writes in a row. While open, register 0x07 holds a logical-device number. Indexes 0x30 and above then reach that device's own bank, while indexes 0x20–0x2F form a global bank shared by all devices. Writing 0xAA to the index port closes access again.

For every logical device the block exports an activate bit, its 16-bit base addresses and its IRQ number and IRQ type. The surrounding logic uses these to place and enable the real peripheral functions. The bus has no back-pressure: a write takes effect at the clock edge where it is presented. A read is answered exactly one cycle later with `io_rvalid` high, and the requester must be ready to take it.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked, every activate bit is 0, every exported base, IRQ, IRQ-type and global register is 0, and a data-port read returns 0xFF.
- R2: Access opens only when two index-port writes in a row both carry 0x87. Any other byte written to the index port while locked restarts the key sequence. Data-port traffic does not affect the sequence.
- R3: An index-port write of 0xAA while open closes access. After that, data-port writes change no register and data-port reads return 0xFF.
- R4: A read of the index port or the data port presented in cycle t returns its data in cycle t+1 with `io_rvalid` high. The index port reads back the current index when open and 0xFF when locked.
- R5: Register 0x07 holds the logical-device number and reads back as written. Device-bank writes (index 0x30 and up) change only the bank of the selected device.
- R6: Bit 0 of device register 0x30 is the activate bit and drives `dev_active[d]`. The other bits read as 0, so writing 0xFF reads back 0x01.
- R7: Each device has NUM_BARS 16-bit base fields. Field k takes its high byte at index 0x60+2k and its low byte at 0x61+2k. Field k of device d is exported at `dev_base[(d*NUM_BARS+k)*16 +: 16]`.
- R8: Device register 0x70 holds the IRQ number and 0x71 the IRQ type. Both are exported per device at `dev_irq[d*8 +: 8]` and `dev_irq_type[d*8 +: 8]`.
- R9: Global registers 0x20–0x2F read back as written whatever the device select is, and are exported at `glob_regs[(i-0x20)*8 +: 8]`.
- R10: An unimplemented index, or a device index while the select is NUM_DEV or higher, reads as 0xFF, and a write to it changes no exported state.
- R11: I/O accesses to addresses other than BASE and BASE+1 are ignored. They give no `io_rvalid`, do not advance the key sequence and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read answer, one cycle after io_rd |
| cfg_unlocked | output | 1 | High while configuration access is open |
| dev_active | output | NUM_DEV | Per-device activate bits |
| dev_base | output | NUM_DEV*NUM_BARS*16 | Per-device base-address fields |
| dev_irq | output | NUM_DEV*8 | Per-device IRQ numbers |
| dev_irq_type | output | NUM_DEV*8 | Per-device IRQ types |
| glob_regs | output | GLOB_N*8 | Global registers 0x20 upward |

## Verification
The bench tries broken keys: a single 0x87 followed by another byte, and 0x87 written at a foreign address. A design that counts key bytes non-consecutively, or decodes too few address bits, would open here. It sweeps every device bank and every global register with arithmetically distinct values and then reads all of them back. A design that ignores the device select, or lets one bank alias another, would show another device's value. Out-of-range selects, unimplemented indexes and data writes after the close byte are checked at the exported fields. A design that decodes loosely or keeps writing after closing would change them.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_OPEN    = 8'h87;
  localparam logic [7:0] KEY_CLOSE   = 8'hAA;
  localparam logic [7:0] IDX_DEVSEL  = 8'h07;
  localparam logic [7:0] IDX_GLOB_LO = 8'h20;
  localparam logic [7:0] IDX_DEV_LO  = 8'h30;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BAR0    = 8'h60;
  localparam logic [7:0] IDX_IRQ     = 8'h70;
  localparam logic [7:0] IDX_IRQTYPE = 8'h71;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open
);
  key_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      unique case (st_q)
        KS_LOCKED: st_d = (wdata == KEY_OPEN) ? KS_ARMED : KS_LOCKED;
        KS_ARMED:  st_d = (wdata == KEY_OPEN) ? KS_OPEN  : KS_LOCKED;
        KS_OPEN:   st_d = (wdata == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
        default:   st_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_LOCKED;
    else        st_q <= st_d;
  end

  assign open = (st_q == KS_OPEN);

  // R2: the open state is only ever entered through the armed state
  a_r2_open_via_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != KS_OPEN) ##1 (st_q == KS_OPEN) |-> $past(st_q == KS_ARMED));
endmodule

// File: rtl/sio_glob_bank.sv
module sio_glob_bank
  import sio_cfg_pkg::*;
#(
  parameter int GLOB_N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        idx,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              hit,
  output logic [GLOB_N*8-1:0] regs
);
  localparam logic [8:0] GLOB_HI = 9'(IDX_GLOB_LO) + 9'(GLOB_N);

  logic [7:0] mem_q [GLOB_N];
  logic [7:0] off;

  assign hit = ({1'b0, idx} >= 9'(IDX_GLOB_LO)) && ({1'b0, idx} < GLOB_HI);
  assign off = idx - IDX_GLOB_LO;

  for (genvar i = 0; i < GLOB_N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem_q[i] <= '0;
      else if (we && hit && off == 8'(i)) mem_q[i] <= wdata;
    end
    assign regs[i*8 +: 8] = mem_q[i];
  end

  always_comb begin
    rdata = 8'hFF;
    for (int i = 0; i < GLOB_N; i++)
      if (hit && off == 8'(i)) rdata = mem_q[i];
  end

  // R9: global bank changes only on a write strobe
  a_r9_glob_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs));
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_BARS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [7:0]             idx,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic                   active,
  output logic [NUM_BARS*16-1:0] base,
  output logic [7:0]             irq,
  output logic [7:0]             irq_type
);
  localparam logic [8:0] BAR_END = 9'(IDX_BAR0) + 9'(2 * NUM_BARS);

  logic       act_q;
  logic [7:0] irq_q, irqt_q;
  logic [7:0] bar_hi_q [NUM_BARS];
  logic [7:0] bar_lo_q [NUM_BARS];
  logic       in_bar;
  logic [7:0] bar_off;

  assign in_bar  = ({1'b0, idx} >= 9'(IDX_BAR0)) && ({1'b0, idx} < BAR_END);
  assign bar_off = idx - IDX_BAR0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      irq_q  <= '0;
      irqt_q <= '0;
    end else if (we) begin
      if (idx == IDX_ACT)     act_q  <= wdata[0];
      if (idx == IDX_IRQ)     irq_q  <= wdata;
      if (idx == IDX_IRQTYPE) irqt_q <= wdata;
    end
  end

  for (genvar k = 0; k < NUM_BARS; k++) begin : g_bar
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bar_hi_q[k] <= '0;
        bar_lo_q[k] <= '0;
      end else if (we && in_bar) begin
        if (bar_off == 8'(2*k))     bar_hi_q[k] <= wdata;
        if (bar_off == 8'(2*k + 1)) bar_lo_q[k] <= wdata;
      end
    end
    assign base[k*16 +: 16] = {bar_hi_q[k], bar_lo_q[k]};
  end

  always_comb begin
    rdata = 8'hFF;
    if (idx == IDX_ACT)     rdata = {7'b0, act_q};
    if (idx == IDX_IRQ)     rdata = irq_q;
    if (idx == IDX_IRQTYPE) rdata = irqt_q;
    for (int k = 0; k < NUM_BARS; k++) begin
      if (in_bar && bar_off == 8'(2*k))     rdata = bar_hi_q[k];
      if (in_bar && bar_off == 8'(2*k + 1)) rdata = bar_lo_q[k];
    end
  end

  assign active   = act_q;
  assign irq      = irq_q;
  assign irq_type = irqt_q;

  // R6: activate bit follows bit 0 of a write to its register
  a_r6_act_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == IDX_ACT) |=> (active == $past(wdata[0])));
  // R5: a bank that is not written keeps its state
  a_r5_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(active) && $stable(base) && $stable(irq) && $stable(irq_type)));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'h0370,
  parameter int              NUM_DEV  = 10,
  parameter int              NUM_BARS = 3,
  parameter int              GLOB_N   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              io_addr,
  input  logic                           io_wr,
  input  logic                           io_rd,
  input  logic [7:0]                     io_wdata,
  output logic [7:0]                     io_rdata,
  output logic                           io_rvalid,
  output logic                           cfg_unlocked,
  output logic [NUM_DEV-1:0]             dev_active,
  output logic [NUM_DEV*NUM_BARS*16-1:0] dev_base,
  output logic [NUM_DEV*8-1:0]           dev_irq,
  output logic [NUM_DEV*8-1:0]           dev_irq_type,
  output logic [GLOB_N*8-1:0]            glob_regs
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE + ADDR_W'(1);
  localparam logic [8:0]        NDEV9     = 9'(NUM_DEV);

  logic       at_idx, at_data, open;
  logic       idx_wr, data_wr;
  logic [7:0] idx_q, sel_q;
  logic       sel_ok, dev_space;
  logic [7:0] glob_rd, dev_rd_mux, data_rd;
  logic       glob_hit;
  logic [7:0] dev_rd [NUM_DEV];

  assign at_idx    = (io_addr == BASE);
  assign at_data   = (io_addr == DATA_ADDR);
  assign idx_wr    = io_wr && at_idx;
  assign data_wr   = io_wr && at_data && open;
  assign sel_ok    = ({1'b0, sel_q} < NDEV9);
  assign dev_space = (idx_q >= IDX_DEV_LO);

  sio_key_fsm u_key (
    .clk   (clk),
    .rst_n (rst_n),
    .idx_wr(idx_wr),
    .wdata (io_wdata),
    .open  (open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= '0;
    end else begin
      if (idx_wr && open && io_wdata != KEY_CLOSE) idx_q <= io_wdata;
      if (data_wr && idx_q == IDX_DEVSEL)          sel_q <= io_wdata;
    end
  end

  sio_glob_bank #(.GLOB_N(GLOB_N)) u_glob (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (data_wr),
    .idx  (idx_q),
    .wdata(io_wdata),
    .rdata(glob_rd),
    .hit  (glob_hit),
    .regs (glob_regs)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic dwe;
    assign dwe = data_wr && dev_space && (sel_q == 8'(d));
    sio_dev_bank #(.NUM_BARS(NUM_BARS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (dwe),
      .idx     (idx_q),
      .wdata   (io_wdata),
      .rdata   (dev_rd[d]),
      .active  (dev_active[d]),
      .base    (dev_base[d*NUM_BARS*16 +: NUM_BARS*16]),
      .irq     (dev_irq[d*8 +: 8]),
      .irq_type(dev_irq_type[d*8 +: 8])
    );
  end

  always_comb begin
    dev_rd_mux = 8'hFF;
    for (int d = 0; d < NUM_DEV; d++)
      if (sel_q == 8'(d)) dev_rd_mux = dev_rd[d];
  end

  always_comb begin
    data_rd = 8'hFF;
    if (open) begin
      if (idx_q == IDX_DEVSEL)       data_rd = sel_q;
      else if (glob_hit)             data_rd = glob_rd;
      else if (dev_space && sel_ok)  data_rd = dev_rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= 8'hFF;
    end else begin
      io_rvalid <= io_rd && (at_idx || at_data);
      if (io_rd && at_idx)       io_rdata <= open ? idx_q : 8'hFF;
      else if (io_rd && at_data) io_rdata <= data_rd;
    end
  end

  assign cfg_unlocked = open;

  // R2: opening is always preceded by a key byte on the index port
  a_r2_key_before_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlocked) |-> $past(io_wr && io_addr == BASE && io_wdata == KEY_OPEN));
  // R3: close byte on the index port shuts access
  a_r3_close: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_unlocked && io_wr && io_addr == BASE && io_wdata == KEY_CLOSE) |=> !cfg_unlocked);
  // R3: locked data writes leave all exported state alone
  a_r3_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unlocked && !(io_wr && io_addr == BASE)) |=>
      ($stable(dev_active) && $stable(dev_irq) && $stable(dev_base) && $stable(glob_regs)));
  // R4: every port read is answered next cycle
  a_r4_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (io_addr == BASE || io_addr == DATA_ADDR)) |=> io_rvalid);
  // R11: foreign addresses produce no answer
  a_r11_no_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && (io_addr == BASE || io_addr == DATA_ADDR)) |=> !io_rvalid);
  // R5: at most one device's activate bit changes per cycle
  a_r5_one_device: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dev_active ^ $past(dev_active)) <= 1);
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 10;
  localparam int NB   = 3;
  localparam int GN   = 16;
  localparam logic [15:0] IDXP = 16'h0370;
  localparam logic [15:0] DATP = 16'h0371;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic io_rvalid, cfg_unlocked;
  logic [NDEV-1:0] dev_active;
  logic [NDEV*NB*16-1:0] dev_base;
  logic [NDEV*8-1:0] dev_irq, dev_irq_type;
  logic [GN*8-1:0] glob_regs;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .cfg_unlocked(cfg_unlocked), .dev_active(dev_active), .dev_base(dev_base),
    .dev_irq(dev_irq), .dev_irq_type(dev_irq_type), .glob_regs(glob_regs)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] v);
    io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v, output logic vld);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    v = io_rdata; vld = io_rvalid;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] v);
    wr(IDXP, i); wr(DATP, v);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] v);
    logic vld;
    wr(IDXP, i); rd(DATP, v, vld);
  endtask

  function automatic logic [15:0] bar_val(input int d, input int k);
    return 16'((d + 1) * 16'h0101 + k * 16'h1111 + 16'h0203);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic vld;
    logic [NDEV*8-1:0] irq_snap;
    logic [GN*8-1:0] glob_snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 unlocked", cfg_unlocked, 0);
    chk("R1 active", dev_active, 0);
    chk("R1 base", dev_base, 0);
    chk("R1 irq", {dev_irq, dev_irq_type}, 0);
    chk("R1 glob", glob_regs, 0);
    rd(DATP, v, vld);
    chk("R1 locked read", v, 8'hFF);
    chk("R4 rvalid", vld, 1);
    rd(IDXP, v, vld);
    chk("R4 locked index read", v, 8'hFF);

    // R11 key at foreign address
    wr(16'h0372, 8'h87); wr(16'h0372, 8'h87);
    chk("R11 foreign key", cfg_unlocked, 0);
    rd(16'h0372, v, vld);
    chk("R11 no rvalid", vld, 0);

    // R2 broken key
    wr(IDXP, 8'h87); wr(IDXP, 8'h55); wr(IDXP, 8'h87);
    chk("R2 broken key", cfg_unlocked, 0);
    wr(IDXP, 8'h87);
    chk("R2 open", cfg_unlocked, 1);
    wr(IDXP, 8'h26);
    rd(IDXP, v, vld);
    chk("R4 index readback", v, 8'h26);

    // R9 global sweep
    for (int i = 0; i < GN; i++) reg_wr(8'(8'h20 + i), 8'(i * 7 + 3));
    reg_wr(8'h07, 8'd4);
    for (int i = 0; i < GN; i++) begin
      reg_rd(8'(8'h20 + i), v);
      chk("R9 glob readback", v, 8'(i * 7 + 3));
      chk("R9 glob export", glob_regs[i*8 +: 8], 8'(i * 7 + 3));
    end

    // R5 R7 R8 R6 device sweep
    for (int d = 0; d < NDEV; d++) begin
      reg_wr(8'h07, 8'(d));
      for (int k = 0; k < NB; k++) begin
        reg_wr(8'(8'h60 + 2*k), bar_val(d, k)[15:8]);
        reg_wr(8'(8'h61 + 2*k), bar_val(d, k)[7:0]);
      end
      reg_wr(8'h70, 8'(d + 3));
      reg_wr(8'h71, 8'(2 + d));
      reg_wr(8'h30, (d % 2 == 1) ? 8'hFF : 8'h00);
    end
    for (int d = 0; d < NDEV; d++) begin
      reg_wr(8'h07, 8'(d));
      reg_rd(8'h07, v);
      chk("R5 select readback", v, 8'(d));
      for (int k = 0; k < NB; k++) begin
        reg_rd(8'(8'h60 + 2*k), v);
        chk("R7 bar high", v, bar_val(d, k)[15:8]);
        reg_rd(8'(8'h61 + 2*k), v);
        chk("R7 bar low", v, bar_val(d, k)[7:0]);
        chk("R7 bar export", dev_base[(d*NB+k)*16 +: 16], bar_val(d, k));
      end
      reg_rd(8'h70, v);
      chk("R8 irq", v, 8'(d + 3));
      chk("R8 irq export", dev_irq[d*8 +: 8], 8'(d + 3));
      chk("R8 type export", dev_irq_type[d*8 +: 8], 8'(2 + d));
      reg_rd(8'h30, v);
      chk("R6 act readback", v, (d % 2 == 1) ? 8'h01 : 8'h00);
      chk("R6 act export", dev_active[d], (d % 2 == 1));
    end

    // R10 out-of-range select and unimplemented index
    irq_snap = dev_irq;
    reg_wr(8'h07, 8'(NDEV));
    reg_wr(8'h70, 8'h5A);
    reg_rd(8'h70, v);
    chk("R10 out-of-range read", v, 8'hFF);
    chk("R10 out-of-range write", dev_irq, irq_snap);
    reg_wr(8'h07, 8'd2);
    reg_wr(8'h50, 8'h33);
    reg_rd(8'h50, v);
    chk("R10 unimplemented read", v, 8'hFF);
    reg_rd(8'h10, v);
    chk("R10 unimplemented low", v, 8'hFF);

    // R3 close and ignore
    wr(IDXP, 8'h70);
    wr(IDXP, 8'hAA);
    chk("R3 closed", cfg_unlocked, 0);
    glob_snap = glob_regs;
    irq_snap = dev_irq;
    wr(DATP, 8'hC3);
    chk("R3 write ignored irq", dev_irq, irq_snap);
    wr(IDXP, 8'h21);
    wr(DATP, 8'hC3);
    chk("R3 write ignored glob", glob_regs, glob_snap);
    chk("R2 single key not open", cfg_unlocked, 0);
    rd(DATP, v, vld);
    chk("R3 locked read", v, 8'hFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule